// File: doc/BRIEF.md
# DRAM Ring-Buffer Address Controller

This block keeps an audio FIFO in an external fast-page-mode DRAM that is four bits wide. Audio arrives one bit at a time. The block groups every four bits into a nibble, most significant bit first, and writes each nibble into the DRAM at the position of a write pointer. A read request fetches the nibble at the read pointer and returns it on a small output port. Both pointers advance through one ring. The ring wraps at the capacity chosen by a geometry input. Each pointer is split into a row part and a column part, and the two parts are sent one after the other on a shared address bus, framed by the RAS and CAS strobes.

A bypass input parks the memory port: every strobe is held inactive and the FIFO is emptied. When bypass is released, the block runs a power-up routine before any normal access. The routine first waits for a programmable number of cycles with all strobes inactive, then issues a fixed number of RAS-only refresh cycles. During normal operation a RAS-only refresh is inserted between accesses at a fixed interval.

When a write and a read are both waiting, the write goes first. A read-halving input makes only every second read request count, which halves the read rate. A flush input empties the FIFO.

Top module: `dram_ring_ctrl`

## Requirements
- R1: While bypass_i is high, ras_n, cas_n, we_n and oe_n are all 1, ready_o is 0 and empty_o is 1, whatever the other inputs do.
- R2: If bypass_i is sampled low at clock edge k, the strobes stay inactive for PWR_WAIT cycles. Then INIT_REF RAS-only refresh cycles follow, each one cycle with RAS low and one cycle with RAS high. ras_n first goes low PWR_WAIT+1 cycles after edge k, ready_o rises PWR_WAIT+2*INIT_REF+1 cycles after edge k, and CAS stays high throughout.
- R3: Each group of four bits taken while ser_vld_i is high forms one nibble. The first bit becomes bit 3. The nibble is written to memory with we_n low while CAS is low.
- R4: A pointer p is put on the bus as row = p >> CW while RAS falls and col = p mod 2^CW while CAS falls. CW is COL_W when geom_big_i = 1 and COL_W-1 when geom_big_i = 0, so the capacity is 2^(2*CW) nibbles.
- R5: Successive writes use pointer values 0, 1, 2, … and successive reads do the same, independently. Each pointer wraps to 0 after capacity-1.
- R6: Each completed read presents the stored nibble on rd_data_o with rd_valid_o high for one cycle. Nibbles come out in the order they were written.
- R7: empty_o is 1 when the pointers are equal. full_o is 1 when capacity nibbles are held. A nibble that completes while the FIFO is full is discarded, with no write access. A read request made while the FIFO is empty is discarded, with no read access.
- R8: When a write and a read become pending in the same cycle, the write access is issued first.
- R9: While rd_half_i is high, read requests alternately count and are dropped. The first request after a flush counts.
- R10: In normal operation a RAS-only refresh (RAS pulse with CAS high) is issued about once every REF_INT cycles.
- R11: A flush_i pulse returns both pointers to 0, so empty_o is 1 and full_o is 0, and the next write uses address 0.
- R12: CAS is never low while RAS is high, and we_n and oe_n are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass_i | input | 1 | Park memory port; falling edge starts power-up |
| geom_big_i | input | 1 | 1: large device (CW=COL_W), 0: small device (CW=COL_W-1) |
| ser_bit_i | input | 1 | Serial audio bit |
| ser_vld_i | input | 1 | Qualifies ser_bit_i |
| rd_req_i | input | 1 | Read request pulse |
| rd_half_i | input | 1 | Halve accepted read requests |
| flush_i | input | 1 | Empty the FIFO |
| rd_data_o | output | NIB_W | Nibble read back |
| rd_valid_o | output | 1 | rd_data_o valid for one cycle |
| full_o | output | 1 | FIFO holds capacity nibbles |
| empty_o | output | 1 | FIFO holds no nibble |
| ready_o | output | 1 | Power-up routine finished |
| dram_addr_o | output | COL_W | Multiplexed row/column address |
| dram_ras_n_o | output | 1 | Row address strobe, active low |
| dram_cas_n_o | output | 1 | Column address strobe, active low |
| dram_we_n_o | output | 1 | Write enable, active low |
| dram_oe_n_o | output | 1 | Output enable, active low |
| dram_dq_o | output | NIB_W | Write data to memory |
| dram_dq_oe_o | output | 1 | Drive enable for dram_dq_o |
| dram_dq_i | input | NIB_W | Read data from memory |

## Verification
A nibble is placed in the write queue two clock edges after its last bit is sampled. The write access starts at the next idle slot, possibly after one refresh. The bench therefore waits at least ten cycles after the last bit before it depends on that write. Read data appears four edges after the read access leaves idle. The bench does not predict that cycle: a monitor samples every falling clock edge, checks each CAS fall against the pointer the bench computes, and pairs every rd_valid_o pulse with the front of its own queue. The power-up timings in R2 are counted exactly from the edge that samples bypass_i low.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
  typedef enum logic [3:0] {
    S_BYP, S_WAIT, S_IRAS, S_IPRE, S_IDLE,
    S_RRAS, S_RPRE, S_AROW, S_ACOL, S_AEND, S_APRE
  } seq_state_t;
endpackage

// File: rtl/dfc_deser.sv
module dfc_deser #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bit_i,
  input  logic             vld_i,
  output logic [NIB_W-1:0] nib_o,
  output logic             nib_stb_o
);
  localparam int CNT_W = $clog2(NIB_W);

  logic [NIB_W-1:0] sr;
  logic [NIB_W-1:0] sr_next;
  logic [CNT_W-1:0] cnt;

  assign sr_next = {sr[NIB_W-2:0], bit_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr <= '0; cnt <= '0; nib_o <= '0; nib_stb_o <= 1'b0;
    end else begin
      nib_stb_o <= 1'b0;
      if (clear) begin
        cnt <= '0;
      end else if (vld_i) begin
        sr <= sr_next;
        if (cnt == CNT_W'(NIB_W-1)) begin
          cnt       <= '0;
          nib_o     <= sr_next;
          nib_stb_o <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dfc_ptrs.sv
module dfc_ptrs #(
  parameter int COL_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            geom_big_i,
  input  logic            wr_adv,
  input  logic            rd_adv,
  output logic [2*COL_W-1:0] wptr_o,
  output logic [2*COL_W-1:0] rptr_o,
  output logic            full_o,
  output logic            empty_o
);
  localparam int AW = 2*COL_W;

  logic [AW:0] wp, rp;

  function automatic logic [AW:0] ring_next(input logic [AW:0] p, input logic big);
    logic [AW-1:0] last;
    last = big ? {AW{1'b1}} : {2'b00, {(AW-2){1'b1}}};
    if (p[AW-1:0] == last) ring_next = {~p[AW], {AW{1'b0}}};
    else                   ring_next = p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      wp <= '0; rp <= '0;
    end else begin
      if (wr_adv) wp <= ring_next(wp, geom_big_i);
      if (rd_adv) rp <= ring_next(rp, geom_big_i);
    end
  end

  assign wptr_o  = wp[AW-1:0];
  assign rptr_o  = rp[AW-1:0];
  assign empty_o = (wp == rp);
  assign full_o  = (wp[AW-1:0] == rp[AW-1:0]) && (wp[AW] != rp[AW]);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !clear) |=> $stable(wptr_o));
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && !clear) |=> $stable(rptr_o));
  assert_full_empty_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && empty_o));
endmodule

// File: rtl/dfc_seq.sv
module dfc_seq
  import dfc_pkg::*;
#(
  parameter int COL_W    = 10,
  parameter int PWR_WAIT = 20000,
  parameter int INIT_REF = 8,
  parameter int REF_INT  = 780
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bypass_i,
  input  logic               geom_big_i,
  input  logic               wr_pend_i,
  input  logic               rd_pend_i,
  input  logic [2*COL_W-1:0] wptr_i,
  input  logic [2*COL_W-1:0] rptr_i,
  output logic [COL_W-1:0]   addr_o,
  output logic               ras_n_o,
  output logic               cas_n_o,
  output logic               we_n_o,
  output logic               oe_n_o,
  output logic               dq_oe_o,
  output logic               wr_done_o,
  output logic               rd_done_o,
  output logic               ready_o,
  output logic               in_bypass_o
);
  localparam int AW    = 2*COL_W;
  localparam int WCW   = $clog2(PWR_WAIT+1);
  localparam int ICW   = $clog2(INIT_REF+1);
  localparam int RCW   = $clog2(REF_INT+1);

  seq_state_t        state;
  logic [WCW-1:0]    wcnt;
  logic [ICW-1:0]    icnt;
  logic [RCW-1:0]    rcnt;
  logic              ref_due;
  logic [COL_W-1:0]  ref_row;
  logic              is_wr;
  logic [AW-1:0]     acc_ptr;
  logic              col_phase;

  function automatic logic [COL_W-1:0] row_of(input logic [AW-1:0] p, input logic big);
    row_of = big ? p[AW-1:COL_W] : {1'b0, p[AW-3:COL_W-1]};
  endfunction

  function automatic logic [COL_W-1:0] col_of(input logic [AW-1:0] p, input logic big);
    col_of = big ? p[COL_W-1:0] : {1'b0, p[COL_W-2:0]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_BYP; wcnt <= '0; icnt <= '0; rcnt <= '0;
      ref_due <= 1'b0; ref_row <= '0; is_wr <= 1'b0; acc_ptr <= '0;
    end else if (bypass_i) begin
      state <= S_BYP; ref_due <= 1'b0; rcnt <= '0;
    end else begin
      if (!ready_o) begin
        rcnt <= '0;
      end else if (rcnt == RCW'(REF_INT-1)) begin
        rcnt <= '0; ref_due <= 1'b1;
      end else begin
        rcnt <= rcnt + 1'b1;
      end
      unique case (state)
        S_BYP:  begin state <= S_WAIT; wcnt <= '0; end
        S_WAIT: begin
          if (wcnt == WCW'(PWR_WAIT-1)) begin state <= S_IRAS; icnt <= '0; end
          else wcnt <= wcnt + 1'b1;
        end
        S_IRAS: begin state <= S_IPRE; ref_row <= ref_row + 1'b1; end
        S_IPRE: begin
          if (icnt == ICW'(INIT_REF-1)) state <= S_IDLE;
          else begin icnt <= icnt + 1'b1; state <= S_IRAS; end
        end
        S_IDLE: begin
          if (ref_due) begin
            state <= S_RRAS; ref_due <= 1'b0;
          end else if (wr_pend_i) begin
            state <= S_AROW; is_wr <= 1'b1; acc_ptr <= wptr_i;
          end else if (rd_pend_i) begin
            state <= S_AROW; is_wr <= 1'b0; acc_ptr <= rptr_i;
          end
        end
        S_RRAS: begin state <= S_RPRE; ref_row <= ref_row + 1'b1; end
        S_RPRE: state <= S_IDLE;
        S_AROW: state <= S_ACOL;
        S_ACOL: state <= S_AEND;
        S_AEND: state <= S_APRE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign col_phase   = (state == S_ACOL) || (state == S_AEND);
  assign ras_n_o     = !((state == S_IRAS) || (state == S_RRAS) || (state == S_AROW) || col_phase);
  assign cas_n_o     = !col_phase;
  assign we_n_o      = !(col_phase && is_wr);
  assign oe_n_o      = !(col_phase && !is_wr);
  assign dq_oe_o     = col_phase && is_wr;
  assign wr_done_o   = (state == S_AEND) && is_wr;
  assign rd_done_o   = (state == S_AEND) && !is_wr;
  assign in_bypass_o = (state == S_BYP);
  assign ready_o     = !((state == S_BYP) || (state == S_WAIT) ||
                         (state == S_IRAS) || (state == S_IPRE));

  always_comb begin
    unique case (state)
      S_IRAS, S_RRAS: addr_o = ref_row;
      S_AROW:         addr_o = row_of(acc_ptr, geom_big_i);
      S_ACOL, S_AEND: addr_o = col_of(acc_ptr, geom_big_i);
      default:        addr_o = '0;
    endcase
  end

  assert_bypass_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_i && $past(bypass_i)) |-> (ras_n_o && cas_n_o && we_n_o && oe_n_o));
  assert_init_no_cas_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> cas_n_o);
  assert_wr_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !ref_due && wr_pend_i && !bypass_i) |=> (state == S_AROW && is_wr));
  assert_cas_in_ras_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n_o |-> !ras_n_o);
  assert_we_oe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n_o && !oe_n_o));
endmodule

// File: rtl/dram_ring_ctrl.sv
module dram_ring_ctrl #(
  parameter int COL_W    = 10,
  parameter int NIB_W    = 4,
  parameter int PWR_WAIT = 20000,
  parameter int INIT_REF = 8,
  parameter int REF_INT  = 780
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bypass_i,
  input  logic             geom_big_i,
  input  logic             ser_bit_i,
  input  logic             ser_vld_i,
  input  logic             rd_req_i,
  input  logic             rd_half_i,
  input  logic             flush_i,
  output logic [NIB_W-1:0] rd_data_o,
  output logic             rd_valid_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             ready_o,
  output logic [COL_W-1:0] dram_addr_o,
  output logic             dram_ras_n_o,
  output logic             dram_cas_n_o,
  output logic             dram_we_n_o,
  output logic             dram_oe_n_o,
  output logic [NIB_W-1:0] dram_dq_o,
  output logic             dram_dq_oe_o,
  input  logic [NIB_W-1:0] dram_dq_i
);
  localparam int AW = 2*COL_W;

  logic             in_byp, clear;
  logic [NIB_W-1:0] nib;
  logic             nib_stb;
  logic             wr_pend, rd_pend, half_tog, rd_take;
  logic             wr_done, rd_done;
  logic [AW-1:0]    wptr, rptr;

  assign clear   = flush_i || in_byp;
  assign rd_take = rd_req_i && (!rd_half_i || !half_tog);

  dfc_deser #(.NIB_W(NIB_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .clear(clear), .bit_i(ser_bit_i),
    .vld_i(ser_vld_i), .nib_o(nib), .nib_stb_o(nib_stb));

  dfc_ptrs #(.COL_W(COL_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .clear(clear), .geom_big_i(geom_big_i),
    .wr_adv(wr_done), .rd_adv(rd_done), .wptr_o(wptr), .rptr_o(rptr),
    .full_o(full_o), .empty_o(empty_o));

  dfc_seq #(.COL_W(COL_W), .PWR_WAIT(PWR_WAIT), .INIT_REF(INIT_REF), .REF_INT(REF_INT)) u_seq (
    .clk(clk), .rst_n(rst_n), .bypass_i(bypass_i), .geom_big_i(geom_big_i),
    .wr_pend_i(wr_pend), .rd_pend_i(rd_pend), .wptr_i(wptr), .rptr_i(rptr),
    .addr_o(dram_addr_o), .ras_n_o(dram_ras_n_o), .cas_n_o(dram_cas_n_o),
    .we_n_o(dram_we_n_o), .oe_n_o(dram_oe_n_o), .dq_oe_o(dram_dq_oe_o),
    .wr_done_o(wr_done), .rd_done_o(rd_done), .ready_o(ready_o),
    .in_bypass_o(in_byp));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      wr_pend <= 1'b0; rd_pend <= 1'b0; half_tog <= 1'b0;
    end else begin
      if (rd_req_i && rd_half_i) half_tog <= ~half_tog;
      if (nib_stb && !full_o && !wr_pend) begin
        wr_pend   <= 1'b1;
        dram_dq_o <= nib;
      end else if (wr_done) begin
        wr_pend <= 1'b0;
      end
      if (rd_take && !empty_o && !rd_pend) rd_pend <= 1'b1;
      else if (rd_done)                    rd_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data_o <= '0; rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_done;
      if (rd_done) rd_data_o <= dram_dq_i;
    end
  end

  assert_rd_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !$past(clear)) |-> !empty_o);
endmodule

// File: tb/dram_ring_ctrl_bench.sv
module dram_ring_ctrl_bench;
  localparam int CW = 3;
  localparam int PW = 20;
  localparam int IR = 8;
  localparam int RI = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bypass = 1'b1, geom = 1'b1, ser_bit = 1'b0, ser_vld = 1'b0;
  logic rd_req = 1'b0, rd_half = 1'b0, flush = 1'b0;
  logic [3:0] rd_data, dq_o, dq_i;
  logic rd_valid, full, empty, ready, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [CW-1:0] addr;

  logic [3:0] mem [64];
  logic [CW-1:0] row_lat = '0;
  logic ras_q = 1'b1, cas_q = 1'b1, pulse_cas = 1'b1;
  int n_checks = 0, n_errs = 0;
  int wp = 0, rp = 0, wr_cas = 0, rd_cas = 0, ref_cnt = 0, rd_cnt = 0, bad_strobe = 0;
  bit last_cas_wr = 0;
  bit done = 0;
  int q[$];

  always #5 clk = ~clk;

  dram_ring_ctrl #(.COL_W(CW), .NIB_W(4), .PWR_WAIT(PW), .INIT_REF(IR), .REF_INT(RI)) u_dram_ring_ctrl (
    .clk(clk), .rst_n(rst_n), .bypass_i(bypass), .geom_big_i(geom),
    .ser_bit_i(ser_bit), .ser_vld_i(ser_vld), .rd_req_i(rd_req), .rd_half_i(rd_half),
    .flush_i(flush), .rd_data_o(rd_data), .rd_valid_o(rd_valid), .full_o(full),
    .empty_o(empty), .ready_o(ready), .dram_addr_o(addr), .dram_ras_n_o(ras_n),
    .dram_cas_n_o(cas_n), .dram_we_n_o(we_n), .dram_oe_n_o(oe_n),
    .dram_dq_o(dq_o), .dram_dq_oe_o(dq_oe), .dram_dq_i(dq_i));

  assign dq_i = (!oe_n && !cas_n) ? mem[{row_lat, addr}] : 4'h0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cap_now();
    return geom ? (1 << (2*CW)) : (1 << (2*(CW-1)));
  endfunction

  function automatic int split(input int p);
    int cw;
    cw = geom ? CW : CW-1;
    return ((p >> cw) * 256) + (p & ((1 << cw) - 1));
  endfunction

  // Memory model and port monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (!ras_n && ras_q) begin row_lat = addr; pulse_cas = 1'b0; end
      if (!cas_n) pulse_cas = 1'b1;
      if (ras_n && !ras_q && !pulse_cas) ref_cnt++;
      if ((!cas_n && ras_n) || (!we_n && !oe_n)) bad_strobe++;
      if (!cas_n && cas_q) begin
        last_cas_wr = !we_n;
        if (!we_n) begin
          wr_cas++;
          chk(split(wp) == row_lat*256 + addr, "R4/R5 write address", row_lat*256 + addr, split(wp));
          wp = (wp + 1) % cap_now();
        end else begin
          rd_cas++;
          chk(split(rp) == row_lat*256 + addr, "R4/R5 read address", row_lat*256 + addr, split(rp));
          rp = (rp + 1) % cap_now();
        end
      end
      if (!cas_n && !we_n) mem[{row_lat, addr}] = dq_o;
      if (rd_valid) begin
        rd_cnt++;
        if (q.size() == 0) chk(0, "R6 read with no data expected", rd_data, -1);
        else begin
          int e;
          e = q.pop_front();
          chk(rd_data == e, "R6 read data order", rd_data, e);
        end
      end
    end
    ras_q = ras_n; cas_q = cas_n;
  end

  task automatic send_nib(input logic [3:0] v, input bit expect_take, input bit req_after);
    for (int b = 3; b >= 0; b--) begin
      @(negedge clk); ser_bit = v[b]; ser_vld = 1'b1;
      @(negedge clk); ser_vld = 1'b0;
      if (b == 0 && req_after) rd_req = 1'b1;
      @(negedge clk); rd_req = 1'b0;
      @(negedge clk);
    end
    if (expect_take) q.push_back(v);
  endtask

  task automatic read_one();
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    wp = 0; rp = 0; q.delete();
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog expired actual=0 expected=1");
      report();
      $finish;
    end
  end

  initial begin
    int first_ras, ready_at, pulses, quiet_bad, c0, c1;
    bit prev_ras;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes in reset", {ras_n,cas_n,we_n,oe_n}, 15);
    chk(!ready && empty && !full, "R1 ready/empty/full in reset", {ready,empty,full}, 2);
    rst_n = 1'b1;
    // R1 bypass ignores activity
    quiet_bad = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      ser_vld = i[0]; ser_bit = i[1]; rd_req = i[2];
      if (!(ras_n && cas_n && we_n && oe_n) || ready || !empty) quiet_bad++;
    end
    ser_vld = 0; rd_req = 0;
    chk(quiet_bad == 0, "R1 bypass holds strobes high", quiet_bad, 0);

    // R2 power-up routine
    bypass = 1'b0;
    first_ras = -1; ready_at = -1; pulses = 0; prev_ras = 1'b1; c0 = 0;
    for (int n = 1; n <= PW + 2*IR + 10; n++) begin
      @(negedge clk);
      if (!ras_n && prev_ras) begin pulses++; if (first_ras < 0) first_ras = n; end
      if (!cas_n) c0++;
      if (ready && ready_at < 0) ready_at = n;
      prev_ras = ras_n;
      if (ready_at > 0) break;
    end
    chk(first_ras == PW + 1, "R2 first RAS after wait", first_ras, PW + 1);
    chk(ready_at == PW + 2*IR + 1, "R2 ready timing", ready_at, PW + 2*IR + 1);
    chk(pulses == IR, "R2 init refresh count", pulses, IR);
    chk(c0 == 0, "R2 no CAS during init", c0, 0);

    // R3 R4 R5 R6 large geometry basic traffic
    geom = 1'b1;
    for (int i = 0; i < 5; i++) send_nib(4'((i*3 + 1) & 15), 1, 0);
    repeat (12) @(negedge clk);
    chk(wr_cas == 5, "R3 five nibbles written", wr_cas, 5);
    for (int i = 0; i < 5; i++) read_one();
    chk(rd_cnt == 5, "R6 five reads returned", rd_cnt, 5);
    chk(empty, "R7 empty after draining", empty, 1);

    // R7 full and overflow, large geometry
    do_flush();
    for (int i = 0; i < 64; i++) send_nib(4'((i*7 + 5) & 15), 1, 0);
    repeat (12) @(negedge clk);
    chk(full && !empty, "R7 full after capacity writes", {full,empty}, 2);
    c0 = wr_cas;
    send_nib(4'hA, 0, 0);
    repeat (12) @(negedge clk);
    chk(wr_cas == c0, "R7 write while full discarded", wr_cas - c0, 0);
    c1 = rd_cnt;
    for (int i = 0; i < 64; i++) read_one();
    chk(rd_cnt - c1 == 64, "R5 full ring read back", rd_cnt - c1, 64);
    chk(empty && !full, "R7 empty after full drain", {full,empty}, 1);
    c0 = rd_cas; c1 = rd_cnt;
    read_one(); repeat (20) @(negedge clk);
    chk(rd_cas == c0 && rd_cnt == c1, "R7 read while empty discarded", rd_cas - c0, 0);

    // R4 R5 small geometry with wrap
    do_flush();
    geom = 1'b0;
    for (int i = 0; i < 40; i++) begin
      send_nib(4'(i & 15), 1, 0);
      repeat (10) @(negedge clk);
      read_one();
    end
    chk(empty && q.size() == 0, "R5 small ring wrapped and drained", q.size(), 0);
    do_flush();
    for (int i = 0; i < 16; i++) send_nib(4'(15 - i), 1, 0);
    repeat (12) @(negedge clk);
    chk(full, "R4 small capacity is 16", full, 1);

    // R11 flush
    do_flush();
    chk(empty && !full, "R11 flush empties", {full,empty}, 1);
    geom = 1'b1;
    send_nib(4'h6, 1, 0);
    repeat (12) @(negedge clk);
    chk(wp == 1, "R11 next write at address 0", wp, 1);
    read_one();

    // R8 write priority
    do_flush();
    send_nib(4'h3, 1, 0);
    repeat (12) @(negedge clk);
    c0 = wr_cas + rd_cas;
    send_nib(4'h9, 1, 1);
    for (int i = 0; i < 30 && (wr_cas + rd_cas) == c0; i++) @(negedge clk);
    chk(last_cas_wr, "R8 write issued before read", last_cas_wr, 1);
    repeat (20) @(negedge clk);
    read_one();
    chk(empty, "R8 both nibbles drained", empty, 1);

    // R9 read halving
    do_flush();
    for (int i = 0; i < 4; i++) send_nib(4'(i + 8), 1, 0);
    repeat (12) @(negedge clk);
    rd_half = 1'b1;
    c1 = rd_cnt;
    for (int i = 0; i < 4; i++) read_one();
    chk(rd_cnt - c1 == 2, "R9 half of requests served", rd_cnt - c1, 2);
    rd_half = 1'b0;
    read_one(); read_one();
    chk(empty, "R9 rest served at full rate", empty, 1);

    // R10 periodic refresh
    c0 = ref_cnt;
    repeat (200) @(negedge clk);
    chk(ref_cnt - c0 >= 3 && ref_cnt - c0 <= 4, "R10 refresh rate", ref_cnt - c0, 3);

    // R12 strobe legality over whole run
    chk(bad_strobe == 0, "R12 strobe combinations", bad_strobe, 0);

    done = 1;
    report();
    $finish;
  end
endmodule